// File: doc/BRIEF.md
# Receive Buffer Pool Tracker

This block keeps the number of free buffer descriptors that remain in one receive pool. Software hands descriptors to the pool through a command path that carries an add strobe and a count. The receive engine takes them back one at a time with a consume strobe. Each consume also carries the address of the descriptor now in use, and the block holds that address in a read-only register.

The host programs a coarse alert level as a 3-bit code. The code is scaled by four, so the thresholds run from 4 to 28 remaining descriptors, and a code of zero turns the alert off. When the remaining count moves onto the threshold, a sticky alert status bit is set. A consume that arrives while the pool is empty is discarded and sets a sticky underflow bit. The host clears either status bit by writing a one to it.

The register interface is 32 bits wide with a two-bit word select. Word 0 is the pool information register, word 1 holds the current descriptor address and word 2 is the status register. Register reads are combinational.

Top module: `rx_pool_tracker`

## Requirements
- R1: After synchronous reset the remaining count, the alert code, the current address and both status bits are zero.
- R2: Word 0 reads as {1'b0, alert code[2:0], 12'b0, remaining count[15:0]}. A write to word 0 loads the alert code from wdata[30:28] and ignores every other bit, and bit 31 and bits 27:16 always read as zero.
- R3: An add strobe without a consume raises the count by add_num on the next edge, and the count saturates at 16'hFFFF.
- R4: A consume strobe without an add lowers a nonzero count by one and loads consume_addr into word 1.
- R5: A consume without an add while the count is zero leaves the count and word 1 unchanged and sets the underflow bit (word 2, bit 1).
- R6: An add and a consume in the same cycle leave the count unchanged, while word 1 still loads consume_addr.
- R7: With a nonzero code N, the alert bit (word 2, bit 0) is set in the cycle where the count changes from a value other than 4*N to exactly 4*N, whether an add or a consume causes the change. A count that stays at 4*N does not set it again.
- R8: With an alert code of zero the alert bit is never set.
- R9: Writing word 2 clears each status bit whose wdata bit (bit 0 alert, bit 1 underflow) is one. A set event in the same cycle wins over the clear.
- R10: Register writes never change the remaining count, and writes to word 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| add_valid | input | 1 | Command strobe that adds descriptors |
| add_num | input | 16 | Number of descriptors to add |
| consume_valid | input | 1 | Receive engine takes one descriptor |
| consume_addr | input | 32 | Start address of the descriptor being taken |
| reg_sel | input | 2 | Register word select: 0 info, 1 address, 2 status |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected word |
| alert_flag | output | 1 | Sticky alert status bit |
| underflow_flag | output | 1 | Sticky underflow status bit |

## Verification
Two event pairs can land on the same edge: an add with a consume, and a status set with the host's write-one-to-clear. The bench provokes the first by pulsing both strobes with the count already at the threshold. It expects the count to hold, the address to load and no new alert. It provokes the second by writing a clear to word 2 in the same cycle in which an add brings the count onto the threshold, and it expects the alert bit to read as one afterwards.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
    localparam int CNT_W  = 16;
    localparam int LVL_W  = 3;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        SEL_INFO   = 2'd0,
        SEL_ADDR   = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic underflow;
        logic alert;
    } status_t;

    typedef struct packed {
        logic             add;
        logic             take;
        logic             underflow;
    } cnt_evt_t;

    function automatic logic [CNT_W-1:0] thr_of(input logic [LVL_W-1:0] code);
        return {{(CNT_W-LVL_W-2){1'b0}}, code, 2'b00};
    endfunction

    function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                                  input logic [CNT_W-1:0] b);
        logic [CNT_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
    endfunction
endpackage

// File: rtl/rxp_count.sv
module rxp_count
    import rxp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             add_valid,
    input  logic [CNT_W-1:0] add_num,
    input  logic             consume_valid,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output cnt_evt_t         evt
);
    always_comb begin
        evt     = '0;
        cnt_nxt = cnt_q;
        if (add_valid && consume_valid) begin
            evt.take = 1'b1;
        end else if (add_valid) begin
            evt.add = 1'b1;
            cnt_nxt = sat_add(cnt_q, add_num);
        end else if (consume_valid) begin
            if (cnt_q == '0) begin
                evt.underflow = 1'b1;
            end else begin
                evt.take = 1'b1;
                cnt_nxt  = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/rxp_alert.sv
module rxp_alert
    import rxp_pkg::*;
(
    input  logic [LVL_W-1:0] lvl,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cnt_nxt,
    output logic             alert_set
);
    logic [CNT_W-1:0] thr;

    always_comb begin
        thr       = thr_of(lvl);
        alert_set = (lvl != '0) && (cnt_nxt == thr) && (cnt_q != thr);
    end
endmodule

// File: rtl/rxp_regs.sv
module rxp_regs
    import rxp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [CNT_W-1:0]  cnt_q,
    input  cnt_evt_t          evt,
    input  logic [ADDR_W-1:0] consume_addr,
    input  logic              alert_set,
    output logic [LVL_W-1:0]  lvl_q,
    output status_t           status_q,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int LVL_LSB = DATA_W - 1 - LVL_W;

    logic [ADDR_W-1:0] addr_q;
    reg_sel_e          sel;
    logic              wr_info, wr_stat;

    always_comb begin
        sel     = reg_sel_e'(reg_sel);
        wr_info = reg_wr && (sel == SEL_INFO);
        wr_stat = reg_wr && (sel == SEL_STATUS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q    <= '0;
            addr_q   <= '0;
            status_q <= '0;
        end else begin
            if (wr_info) lvl_q <= reg_wdata[LVL_LSB +: LVL_W];
            if (evt.take) addr_q <= consume_addr;
            status_q.alert     <= alert_set ||
                                  (status_q.alert && !(wr_stat && reg_wdata[0]));
            status_q.underflow <= evt.underflow ||
                                  (status_q.underflow && !(wr_stat && reg_wdata[1]));
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_INFO: begin
                reg_rdata[CNT_W-1:0]            = cnt_q;
                reg_rdata[LVL_LSB +: LVL_W]     = lvl_q;
            end
            SEL_ADDR:   reg_rdata[ADDR_W-1:0]   = addr_q;
            SEL_STATUS: reg_rdata[1:0]          = status_q;
            default:    reg_rdata               = '0;
        endcase
    end
endmodule

// File: rtl/rx_pool_tracker.sv
module rx_pool_tracker
    import rxp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              add_valid,
    input  logic [15:0]       add_num,
    input  logic              consume_valid,
    input  logic [31:0]       consume_addr,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              alert_flag,
    output logic              underflow_flag
);
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic [LVL_W-1:0] lvl_q;
    cnt_evt_t         evt;
    status_t          status_q;
    logic             alert_set;

    rxp_count u_count (
        .clk           (clk),
        .rst           (rst),
        .add_valid     (add_valid),
        .add_num       (add_num),
        .consume_valid (consume_valid),
        .cnt_q         (cnt_q),
        .cnt_nxt       (cnt_nxt),
        .evt           (evt)
    );

    rxp_alert u_alert (
        .lvl       (lvl_q),
        .cnt_q     (cnt_q),
        .cnt_nxt   (cnt_nxt),
        .alert_set (alert_set)
    );

    rxp_regs #(.ADDR_W(32)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .reg_sel      (reg_sel),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .cnt_q        (cnt_q),
        .evt          (evt),
        .consume_addr (consume_addr),
        .alert_set    (alert_set),
        .lvl_q        (lvl_q),
        .status_q     (status_q),
        .reg_rdata    (reg_rdata)
    );

    assign alert_flag     = status_q.alert;
    assign underflow_flag = status_q.underflow;
endmodule

// File: rtl/rxp_checker.sv
module rxp_checker (
    input logic        clk,
    input logic        rst,
    input logic        add_valid,
    input logic [15:0] add_num,
    input logic        consume_valid,
    input logic        reg_wr,
    input logic [1:0]  reg_sel,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic [15:0] cnt_q,
    input logic [2:0]  lvl_q,
    input logic        alert_flag,
    input logic        underflow_flag
);
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 2'd0) |-> (reg_rdata[31] == 1'b0 && reg_rdata[27:16] == 12'h000)); // R2

    AST_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (add_valid && !consume_valid && cnt_q == 16'hFFFF) |=> (cnt_q == 16'hFFFF)); // R3

    AST_UNDERFLOW_SET: assert property (@(posedge clk) disable iff (rst)
        (consume_valid && !add_valid && cnt_q == 16'h0000) |=> (underflow_flag && cnt_q == 16'h0000)); // R5

    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (add_valid && consume_valid) |=> (cnt_q == $past(cnt_q))); // R6

    AST_ALERT_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (lvl_q != 3'd0 && cnt_q != {11'b0, lvl_q, 2'b00}) ##1
        (cnt_q == {11'b0, $past(lvl_q), 2'b00}) |-> alert_flag); // R7

    AST_ALERT_OFF: assert property (@(posedge clk) disable iff (rst)
        (lvl_q == 3'd0 && !alert_flag) |=> !alert_flag); // R8

    AST_NO_REG_COUNT: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !add_valid && !consume_valid) |=> $stable(cnt_q)); // R10
endmodule

bind rx_pool_tracker rxp_checker u_rxp_checker (
    .clk            (clk),
    .rst            (rst),
    .add_valid      (add_valid),
    .add_num        (add_num),
    .consume_valid  (consume_valid),
    .reg_wr         (reg_wr),
    .reg_sel        (reg_sel),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .cnt_q          (cnt_q),
    .lvl_q          (lvl_q),
    .alert_flag     (alert_flag),
    .underflow_flag (underflow_flag)
);

// File: tb/test_rx_pool_tracker.sv
module test_rx_pool_tracker;
    localparam time CLK_P = 10ns;
    localparam int  WATCHDOG = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        add_valid = 1'b0;
    logic [15:0] add_num = '0;
    logic        consume_valid = 1'b0;
    logic [31:0] consume_addr = '0;
    logic [1:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        alert_flag, underflow_flag;

    rx_pool_tracker i_rx_pool_tracker (
        .clk(clk), .rst(rst), .add_valid(add_valid), .add_num(add_num),
        .consume_valid(consume_valid), .consume_addr(consume_addr),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .alert_flag(alert_flag),
        .underflow_flag(underflow_flag)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model of the pool, built from the requirements
    logic [15:0] m_cnt = '0;
    logic [31:0] m_addr = '0;
    logic [2:0]  m_lvl = '0;
    logic        m_alert = 1'b0;
    logic        m_unf = 1'b0;

    function automatic logic [31:0] info_word();
        return {1'b0, m_lvl, 12'h000, m_cnt};
    endfunction

    task automatic step(input logic a, input logic [15:0] n, input logic c,
                        input logic [31:0] ca, input logic w,
                        input logic [1:0] wa, input logic [31:0] wd);
        logic [15:0] nxt;
        logic [16:0] sum;
        logic        unf_set, a_set, take;
        @(negedge clk);
        add_valid = a; add_num = n; consume_valid = c; consume_addr = ca;
        reg_wr = w; reg_sel = wa; reg_wdata = wd;
        unf_set = 1'b0; take = 1'b0; nxt = m_cnt;
        if (a && c) take = 1'b1;
        else if (a) begin
            sum = {1'b0, m_cnt} + {1'b0, n};
            nxt = sum[16] ? 16'hFFFF : sum[15:0];
        end else if (c) begin
            if (m_cnt == 0) unf_set = 1'b1;
            else begin nxt = m_cnt - 1; take = 1'b1; end
        end
        a_set = (m_lvl != 0) && (nxt == {11'b0, m_lvl, 2'b00}) &&
                (m_cnt != {11'b0, m_lvl, 2'b00});
        if (take) m_addr = ca;
        m_alert = a_set | (m_alert & ~(w && wa == 2'd2 && wd[0]));
        m_unf   = unf_set | (m_unf & ~(w && wa == 2'd2 && wd[1]));
        if (w && wa == 2'd0) m_lvl = wd[30:28];
        m_cnt = nxt;
        @(posedge clk);
        #1;
        add_valid = 1'b0; consume_valid = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic chk(input logic [1:0] sel, input logic [31:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        reg_sel = sel;
        it.exp = exp; it.tag = tag;
        q.push_back(it);
        @(posedge clk);
    endtask

    task automatic chk_all(input string tag);
        chk(2'd0, info_word(), tag);
        chk(2'd1, m_addr, tag);
        chk(2'd2, {30'b0, m_unf, m_alert}, tag);
    endtask

    // monitor: compares each queued expectation with the read data
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_chk++;
                if (reg_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: sel=%0d actual=%h expected=%h",
                             it.tag, reg_sel, reg_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk_all("R1 reset");

        // R2/R10: level 2 -> threshold 8; reserved bits written as ones read zero
        step(0, 0, 0, 0, 1, 2'd0, 32'hAFFF_FFFF);
        chk(2'd0, 32'h2000_0000, "R2 info layout R10 count unchanged");

        // R5: consume on empty pool
        step(0, 0, 1, 32'hDEAD_0000, 0, 0, 0);
        chk_all("R5 underflow");

        // R9: clear underflow
        step(0, 0, 0, 0, 1, 2'd2, 32'h2);
        chk(2'd2, 32'h0, "R9 clear underflow");

        // R3: add 10, skipping over 8 without landing does not alert
        step(1, 16'd10, 0, 0, 0, 0, 0);
        chk_all("R3 add");

        // R4: consume
        step(0, 0, 1, 32'h0000_1000, 0, 0, 0);
        chk_all("R4 consume");

        // R7: consume onto threshold 8
        step(0, 0, 1, 32'h0000_1010, 0, 0, 0);
        chk(2'd2, 32'h1, "R7 alert by consume");
        step(0, 0, 0, 0, 1, 2'd2, 32'h1);
        chk(2'd2, 32'h0, "R9 clear alert");

        // R6: add and consume together at the threshold
        step(1, 16'd5, 1, 32'h0000_1020, 0, 0, 0);
        chk_all("R6 simultaneous R7 no re-alert");

        // R7: dwell at threshold does not re-set
        step(0, 0, 0, 0, 0, 0, 0);
        chk(2'd2, 32'h0, "R7 dwell");

        // R7 by add, and R9 set wins over clear
        step(0, 0, 1, 32'h0000_1030, 0, 0, 0);
        chk(2'd0, info_word(), "R4 down to 7");
        step(1, 16'd1, 0, 0, 1, 2'd2, 32'h1);
        chk(2'd2, 32'h1, "R7 alert by add R9 set wins");

        // R10: write word 1 is ignored
        step(0, 0, 0, 0, 1, 2'd1, 32'h5555_AAAA);
        chk_all("R10 address write ignored");

        // R8: code zero disables alert
        step(0, 0, 0, 0, 1, 2'd2, 32'h3);
        step(0, 0, 0, 0, 1, 2'd0, 32'h0);
        for (int i = 0; i < 8; i++) step(0, 0, 1, 32'h2000 + 32'(i), 0, 0, 0);
        step(1, 16'd4, 0, 0, 0, 0, 0);
        chk_all("R8 alert disabled");

        // R7 with code 7 -> threshold 28
        step(0, 0, 0, 0, 1, 2'd0, 32'h7000_0000);
        step(1, 16'd24, 0, 0, 0, 0, 0);
        chk_all("R7 code 7 threshold 28");

        // R3: saturation
        step(1, 16'hFFFF, 0, 0, 0, 0, 0);
        chk(2'd0, info_word(), "R3 saturate");
        step(1, 16'd5, 0, 0, 0, 0, 0);
        chk(2'd0, 32'h7000_FFFF, "R3 hold at max");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule